// File: doc/BRIEF.md
# Scoreboard Issue Stage With Dual Dispatch

This stage holds a single decoded instruction and decides, each cycle, whether it can leave. Scalar operands are checked against a ready table that keeps a separate ready bit for every register of every warp. Vector operands are checked against one ready table that all warps share. When the operands are ready, the instruction goes to one of two slots. Memory operations go to the load/store slot, and everything else goes to the execute slot. On issue, the stage marks the destination registers busy.

When the held instruction cannot leave, the stage raises a stall toward fetch/decode, and no new instruction enters. The writeback port marks registers ready again. A release that arrives in the same cycle as an operand check is seen by that check. The load/store slot accepts a new operation only after a fixed memory latency has expired and while the unit reports no stall of its own. The execute slot always accepts.

Top module: `sb_issue_stage`

## Requirements
- R1: After reset, every scalar and vector register reads as ready, `stall_o`, `exe_valid_o` and `lsu_valid_o` are 0, and an instruction whose sources are all nonzero issues in the cycle after it is loaded.
- R2: Issuing an instruction with `in_rd_en_i`=1 and a nonzero `in_rd_i` marks that register busy for its own warp only. A later instruction of that warp that reads the register (through rs1 or rs2) stalls, and an instruction of another warp that reads the same index does not stall.
- R3: Issuing with `in_vd_en_i`=1 and a nonzero `in_vd_i` marks that vector register busy for all warps. A later reader through vs1 or vs2 stalls, whatever its warp.
- R4: A source index of 0 is never checked. A destination index of 0 is never marked busy.
- R5: While the held instruction cannot issue, `stall_o` is 1, both issue valids are 0, and the held fields stay unchanged. The instruction later issues with the same fields, in program order.
- R6: A writeback with `wb_valid_i`=1 and a nonzero `wb_rd_i` (for the table of warp `wb_warp_i`) or a nonzero `wb_vd_i` (shared table) marks that register ready. A stalled instruction waiting on it issues in that same cycle.
- R7: An instruction with `in_is_mem_i`=1 issues on `lsu_valid_o`, and any other instruction issues on `exe_valid_o`. The two are never 1 together.
- R8: After a load/store dispatch, the next one comes no earlier than MEM_LAT+1 cycles later (6 with defaults). Execute issues are not delayed by this window.
- R9: While `lsu_stall_i` is 1, a memory instruction does not issue. A non-memory instruction still issues.
- R10: When an instruction issues and a writeback releases its own destination in the same cycle, the destination ends up busy.
- R11: `stall_o` is 0 whenever the slot is empty or its instruction issues. The input is taken at a clock edge exactly when `in_valid_i`=1 and `stall_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_warp_i | input | $clog2(NUM_WARPS) | Warp of the instruction |
| in_rs1_i | input | $clog2(NUM_REGS) | Scalar source 1, 0 = none |
| in_rs2_i | input | $clog2(NUM_REGS) | Scalar source 2, 0 = none |
| in_rd_i | input | $clog2(NUM_REGS) | Scalar destination |
| in_rd_en_i | input | 1 | Scalar destination present |
| in_vs1_i | input | $clog2(NUM_VREGS) | Vector source 1, 0 = none |
| in_vs2_i | input | $clog2(NUM_VREGS) | Vector source 2, 0 = none |
| in_vd_i | input | $clog2(NUM_VREGS) | Vector destination |
| in_vd_en_i | input | 1 | Vector destination present |
| in_is_mem_i | input | 1 | Load or store |
| stall_o | output | 1 | Held instruction cannot issue |
| wb_valid_i | input | 1 | Writeback release valid |
| wb_warp_i | input | $clog2(NUM_WARPS) | Warp of released scalar register |
| wb_rd_i | input | $clog2(NUM_REGS) | Released scalar register, 0 = none |
| wb_vd_i | input | $clog2(NUM_VREGS) | Released vector register, 0 = none |
| lsu_stall_i | input | 1 | Load/store unit is itself stalled |
| exe_valid_o | output | 1 | Issue to execute slot |
| lsu_valid_o | output | 1 | Issue to load/store slot |
| iss_warp_o | output | $clog2(NUM_WARPS) | Held warp |
| iss_rd_o | output | $clog2(NUM_REGS) | Held scalar destination |
| iss_rd_en_o | output | 1 | Held scalar destination present |
| iss_vd_o | output | $clog2(NUM_VREGS) | Held vector destination |
| iss_vd_en_o | output | 1 | Held vector destination present |

## Verification
The case hardest to reach from the ports is an issue and a release that hit the same register in one cycle. The writeback has to be driven in exactly the cycle in which the held instruction issues. The bench gets there by loading the instruction and pulsing the release in the cycle that follows the load. A dependent reader is then sent, and it must stall, which shows that busy won. The release bypass is reached the same way: a dependent instruction is left stalled for several cycles, and the release is pulsed once. The issue must appear in that cycle and not in the one after.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_EXE  = 2'd1,
    ROUTE_LSU  = 2'd2
  } route_e;
endpackage

// File: rtl/sb_ready_table.sv
module sb_ready_table #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW  = $clog2(COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] rd_row_i,
  input  logic [IW-1:0] rd_a_idx_i,
  input  logic [IW-1:0] rd_b_idx_i,
  output logic          rd_a_rdy_o,
  output logic          rd_b_rdy_o,
  input  logic          busy_en_i,
  input  logic [RW-1:0] busy_row_i,
  input  logic [IW-1:0] busy_idx_i,
  input  logic          rel_en_i,
  input  logic [RW-1:0] rel_row_i,
  input  logic [IW-1:0] rel_idx_i
);
  logic [ROWS-1:0][COLS-1:0] rdy_q;
  logic fwd_a, fwd_b;

  // same-cycle release is forwarded to readers
  assign fwd_a = rel_en_i && (rel_row_i == rd_row_i) && (rel_idx_i == rd_a_idx_i);
  assign fwd_b = rel_en_i && (rel_row_i == rd_row_i) && (rel_idx_i == rd_b_idx_i);
  assign rd_a_rdy_o = rdy_q[rd_row_i][rd_a_idx_i] | fwd_a;
  assign rd_b_rdy_o = rdy_q[rd_row_i][rd_b_idx_i] | fwd_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= '1;
    end else begin
      if (rel_en_i)  rdy_q[rel_row_i][rel_idx_i]   <= 1'b1;
      // busy wins over a same-cycle release
      if (busy_en_i) rdy_q[busy_row_i][busy_idx_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_mem_timer.sv
module sb_mem_timer #(
  parameter int LAT = 5,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(LAT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sb_issue_stage.sv
module sb_issue_stage #(
  parameter int NUM_WARPS = 32,
  parameter int NUM_REGS  = 32,
  parameter int NUM_VREGS = 32,
  parameter int MEM_LAT   = 5,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS),
  localparam int VW = $clog2(NUM_VREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [WW-1:0] in_warp_i,
  input  logic [RW-1:0] in_rs1_i,
  input  logic [RW-1:0] in_rs2_i,
  input  logic [RW-1:0] in_rd_i,
  input  logic          in_rd_en_i,
  input  logic [VW-1:0] in_vs1_i,
  input  logic [VW-1:0] in_vs2_i,
  input  logic [VW-1:0] in_vd_i,
  input  logic          in_vd_en_i,
  input  logic          in_is_mem_i,
  output logic          stall_o,
  input  logic          wb_valid_i,
  input  logic [WW-1:0] wb_warp_i,
  input  logic [RW-1:0] wb_rd_i,
  input  logic [VW-1:0] wb_vd_i,
  input  logic          lsu_stall_i,
  output logic          exe_valid_o,
  output logic          lsu_valid_o,
  output logic [WW-1:0] iss_warp_o,
  output logic [RW-1:0] iss_rd_o,
  output logic          iss_rd_en_o,
  output logic [VW-1:0] iss_vd_o,
  output logic          iss_vd_en_o
);
  import sb_pkg::*;

  typedef struct packed {
    logic          valid;
    logic [WW-1:0] warp;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic [RW-1:0] rd;
    logic          rd_en;
    logic [VW-1:0] vs1;
    logic [VW-1:0] vs2;
    logic [VW-1:0] vd;
    logic          vd_en;
    logic          is_mem;
  } slot_t;

  slot_t  slot_q, slot_d;
  route_e route;
  logic   sc_a_rdy, sc_b_rdy, vc_a_rdy, vc_b_rdy;
  logic   src_ok, lsu_busy, tmr_busy, can_issue;
  logic   sc_busy_en, vc_busy_en, sc_rel_en, vc_rel_en;

  // scalar table: one row per warp
  sb_ready_table #(.ROWS(NUM_WARPS), .COLS(NUM_REGS)) u_sc_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_row_i   (slot_q.warp),
    .rd_a_idx_i (slot_q.rs1),
    .rd_b_idx_i (slot_q.rs2),
    .rd_a_rdy_o (sc_a_rdy),
    .rd_b_rdy_o (sc_b_rdy),
    .busy_en_i  (sc_busy_en),
    .busy_row_i (slot_q.warp),
    .busy_idx_i (slot_q.rd),
    .rel_en_i   (sc_rel_en),
    .rel_row_i  (wb_warp_i),
    .rel_idx_i  (wb_rd_i)
  );

  // vector table: single row shared by all warps
  sb_ready_table #(.ROWS(1), .COLS(NUM_VREGS)) u_vc_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_row_i   (1'b0),
    .rd_a_idx_i (slot_q.vs1),
    .rd_b_idx_i (slot_q.vs2),
    .rd_a_rdy_o (vc_a_rdy),
    .rd_b_rdy_o (vc_b_rdy),
    .busy_en_i  (vc_busy_en),
    .busy_row_i (1'b0),
    .busy_idx_i (slot_q.vd),
    .rel_en_i   (vc_rel_en),
    .rel_row_i  (1'b0),
    .rel_idx_i  (wb_vd_i)
  );

  sb_mem_timer #(.LAT(MEM_LAT)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lsu_valid_o),
    .busy_o (tmr_busy)
  );

  assign src_ok = ((slot_q.rs1 == '0) || sc_a_rdy) &&
                  ((slot_q.rs2 == '0) || sc_b_rdy) &&
                  ((slot_q.vs1 == '0) || vc_a_rdy) &&
                  ((slot_q.vs2 == '0) || vc_b_rdy);

  assign lsu_busy  = tmr_busy || lsu_stall_i;
  assign can_issue = slot_q.valid && src_ok && !(slot_q.is_mem && lsu_busy);

  always_comb begin
    route = ROUTE_NONE;
    if (can_issue) route = slot_q.is_mem ? ROUTE_LSU : ROUTE_EXE;
  end

  assign exe_valid_o = (route == ROUTE_EXE);
  assign lsu_valid_o = (route == ROUTE_LSU);
  assign stall_o     = slot_q.valid && !can_issue;

  assign sc_busy_en = can_issue && slot_q.rd_en && (slot_q.rd != '0);
  assign vc_busy_en = can_issue && slot_q.vd_en && (slot_q.vd != '0);
  assign sc_rel_en  = wb_valid_i && (wb_rd_i != '0);
  assign vc_rel_en  = wb_valid_i && (wb_vd_i != '0);

  always_comb begin
    slot_d = slot_q;
    if (!stall_o) begin
      slot_d.valid  = in_valid_i;
      slot_d.warp   = in_warp_i;
      slot_d.rs1    = in_rs1_i;
      slot_d.rs2    = in_rs2_i;
      slot_d.rd     = in_rd_i;
      slot_d.rd_en  = in_rd_en_i;
      slot_d.vs1    = in_vs1_i;
      slot_d.vs2    = in_vs2_i;
      slot_d.vd     = in_vd_i;
      slot_d.vd_en  = in_vd_en_i;
      slot_d.is_mem = in_is_mem_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d;
  end

  assign iss_warp_o  = slot_q.warp;
  assign iss_rd_o    = slot_q.rd;
  assign iss_rd_en_o = slot_q.rd_en;
  assign iss_vd_o    = slot_q.vd;
  assign iss_vd_en_o = slot_q.vd_en;
endmodule

// File: rtl/sb_issue_stage_chk.sv
module sb_issue_stage_chk #(
  parameter int NUM_WARPS = 32,
  parameter int NUM_REGS  = 32,
  parameter int MEM_LAT   = 5,
  localparam int WW = $clog2(NUM_WARPS),
  localparam int RW = $clog2(NUM_REGS),
  localparam int GW = $clog2(MEM_LAT + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall_o,
  input logic          exe_valid_o,
  input logic          lsu_valid_o,
  input logic          lsu_stall_i,
  input logic [WW-1:0] iss_warp_o,
  input logic [RW-1:0] iss_rd_o
);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= GW'(MEM_LAT + 1);
    else if (lsu_valid_o)              gap_q <= GW'(1);
    else if (gap_q < GW'(MEM_LAT + 1)) gap_q <= gap_q + GW'(1);
  end

  p_one_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exe_valid_o && lsu_valid_o));

  p_stall_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!exe_valid_o && !lsu_valid_o));

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ($stable(iss_warp_o) && $stable(iss_rd_o)));

  p_mem_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsu_valid_o |-> (gap_q == GW'(MEM_LAT + 1)));

  p_lsu_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsu_stall_i |-> !lsu_valid_o);
endmodule

bind sb_issue_stage sb_issue_stage_chk #(
  .NUM_WARPS (NUM_WARPS),
  .NUM_REGS  (NUM_REGS),
  .MEM_LAT   (MEM_LAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_o     (stall_o),
  .exe_valid_o (exe_valid_o),
  .lsu_valid_o (lsu_valid_o),
  .lsu_stall_i (lsu_stall_i),
  .iss_warp_o  (iss_warp_o),
  .iss_rd_o    (iss_rd_o)
);

// File: tb/sb_issue_stage_bench.sv
`timescale 1ns/1ps
module sb_issue_stage_bench;
  localparam int MEM_LAT = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [4:0] in_warp_i = '0, in_rs1_i = '0, in_rs2_i = '0, in_rd_i = '0;
  logic       in_rd_en_i = 1'b0;
  logic [4:0] in_vs1_i = '0, in_vs2_i = '0, in_vd_i = '0;
  logic       in_vd_en_i = 1'b0, in_is_mem_i = 1'b0;
  logic       stall_o;
  logic       wb_valid_i = 1'b0;
  logic [4:0] wb_warp_i = '0, wb_rd_i = '0, wb_vd_i = '0;
  logic       lsu_stall_i = 1'b0;
  logic       exe_valid_o, lsu_valid_o, iss_rd_en_o, iss_vd_en_o;
  logic [4:0] iss_warp_o, iss_rd_o, iss_vd_o;

  always #2 clk = ~clk;

  sb_issue_stage u_sb_issue_stage (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_warp_i(in_warp_i), .in_rs1_i(in_rs1_i),
    .in_rs2_i(in_rs2_i), .in_rd_i(in_rd_i), .in_rd_en_i(in_rd_en_i),
    .in_vs1_i(in_vs1_i), .in_vs2_i(in_vs2_i), .in_vd_i(in_vd_i),
    .in_vd_en_i(in_vd_en_i), .in_is_mem_i(in_is_mem_i), .stall_o(stall_o),
    .wb_valid_i(wb_valid_i), .wb_warp_i(wb_warp_i), .wb_rd_i(wb_rd_i),
    .wb_vd_i(wb_vd_i), .lsu_stall_i(lsu_stall_i),
    .exe_valid_o(exe_valid_o), .lsu_valid_o(lsu_valid_o),
    .iss_warp_o(iss_warp_o), .iss_rd_o(iss_rd_o), .iss_rd_en_o(iss_rd_en_o),
    .iss_vd_o(iss_vd_o), .iss_vd_en_o(iss_vd_en_o)
  );

  typedef struct {
    bit mem;
    int warp;
    int rd;
    bit rd_en;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0;
  int   cyc = 0;
  int   n_lsu = 0, last_lsu_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: pop expected item on every issue
  always @(negedge clk) begin
    if (rst_ni && (exe_valid_o || lsu_valid_o)) begin
      if (lsu_valid_o) begin
        n_lsu++;
        last_lsu_cyc = cyc;
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected issue", int'(iss_warp_o), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(lsu_valid_o == e.mem, "R7 route", int'(lsu_valid_o), int'(e.mem));
        chk(int'(iss_warp_o) == e.warp, "R5 warp", int'(iss_warp_o), e.warp);
        chk(iss_rd_en_o == e.rd_en && (!e.rd_en || int'(iss_rd_o) == e.rd),
            "R5 dest", int'(iss_rd_o), e.rd);
      end
    end
  end

  task automatic send(input bit mem, input int w, input int rs1, input int rs2,
                      input int rd, input bit rden, input int vs1, input int vs2,
                      input int vd, input bit vden);
    exp_t e;
    bit   acc;
    e.mem = mem; e.warp = w; e.rd = rd; e.rd_en = rden;
    exp_q.push_back(e);
    in_valid_i = 1'b1; in_is_mem_i = mem; in_warp_i = 5'(w);
    in_rs1_i = 5'(rs1); in_rs2_i = 5'(rs2); in_rd_i = 5'(rd); in_rd_en_i = rden;
    in_vs1_i = 5'(vs1); in_vs2_i = 5'(vs2); in_vd_i = 5'(vd); in_vd_en_i = vden;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      acc = !stall_o;
      @(posedge clk); #1;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic release_issue(input int w, input int rd, input int vd, input string req);
    wb_valid_i = 1'b1; wb_warp_i = 5'(w); wb_rd_i = 5'(rd); wb_vd_i = 5'(vd);
    @(negedge clk);
    chk(exe_valid_o && !stall_o, req, int'(exe_valid_o), 1);
    @(posedge clk); #1;
    wb_valid_i = 1'b0; wb_rd_i = '0; wb_vd_i = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(!stall_o && !exe_valid_o && !lsu_valid_o, "R1 reset outputs", int'(stall_o), 0);
    @(posedge clk); #1;

    // R1: all registers ready after reset
    send(0, 31, 31, 30, 0, 0, 31, 1, 0, 0);
    @(negedge clk);
    chk(exe_valid_o, "R1 ready at reset R11", int'(exe_valid_o), 1);
    @(posedge clk); #1;

    // R2/R6: scalar dependency within a warp, release bypass
    send(0, 3, 0, 0, 7, 1, 0, 0, 0, 0);
    send(0, 3, 7, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(stall_o && !exe_valid_o, "R2 same-warp stall R5", int'(stall_o), 1);
    end
    @(posedge clk); #1;
    release_issue(3, 7, 0, "R6 release bypass");

    // R2: other warp not affected
    send(0, 4, 0, 0, 9, 1, 0, 0, 0, 0);
    send(0, 5, 9, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(exe_valid_o && int'(iss_warp_o) == 5, "R2 other warp free", int'(exe_valid_o), 1);
    @(posedge clk); #1;
    send(0, 4, 0, 9, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(stall_o, "R2 rs2 busy", int'(stall_o), 1);
    @(posedge clk); #1;
    release_issue(4, 9, 0, "R6 scalar release");

    // R3: vector table shared across warps
    send(0, 1, 0, 0, 0, 0, 0, 0, 4, 1);
    send(0, 2, 0, 0, 0, 0, 0, 4, 0, 0);
    @(negedge clk);
    chk(stall_o, "R3 shared vector stall", int'(stall_o), 1);
    @(posedge clk); #1;
    release_issue(9, 0, 4, "R3 vector release R6");

    // R4: index zero never tracked
    send(0, 6, 0, 0, 0, 1, 0, 0, 0, 1);
    send(0, 6, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(exe_valid_o, "R4 zero index", int'(exe_valid_o), 1);
    @(posedge clk); #1;

    // R8: memory latency window
    send(1, 0, 0, 0, 10, 1, 0, 0, 0, 0);
    send(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    base = last_lsu_cyc;
    @(negedge clk);
    chk(stall_o, "R8 lsu busy stall", int'(stall_o), 1);
    wait (n_lsu == 2);
    #0.1;
    chk(last_lsu_cyc - base == MEM_LAT + 1, "R8 mem gap", last_lsu_cyc - base, MEM_LAT + 1);
    @(posedge clk); #1;
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(exe_valid_o, "R8 exe not held", int'(exe_valid_o), 1);
    @(posedge clk); #1;
    release_issue_idle(0, 10);
    repeat (MEM_LAT + 2) @(posedge clk);
    #1;

    // R9: unit stall blocks memory only
    lsu_stall_i = 1'b1;
    send(0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(exe_valid_o, "R9 exe during unit stall", int'(exe_valid_o), 1);
    @(posedge clk); #1;
    send(1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(stall_o && !lsu_valid_o, "R9 mem blocked", int'(lsu_valid_o), 0);
    end
    @(posedge clk); #1;
    lsu_stall_i = 1'b0;
    @(negedge clk);
    chk(lsu_valid_o, "R9 mem after unit stall", int'(lsu_valid_o), 1);
    @(posedge clk); #1;

    // R10: issue and release of the same destination in one cycle
    send(0, 7, 0, 0, 12, 1, 0, 0, 0, 0);
    wb_valid_i = 1'b1; wb_warp_i = 5'd7; wb_rd_i = 5'd12;
    @(negedge clk);
    chk(exe_valid_o, "R10 issue", int'(exe_valid_o), 1);
    @(posedge clk); #1;
    wb_valid_i = 1'b0; wb_rd_i = '0;
    send(0, 7, 12, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(stall_o, "R10 busy wins", int'(stall_o), 1);
    @(posedge clk); #1;
    release_issue(7, 12, 0, "R10 final release");

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all issued in order", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // release with nothing waiting
  task automatic release_issue_idle(input int w, input int rd);
    wb_valid_i = 1'b1; wb_warp_i = 5'(w); wb_rd_i = 5'(rd);
    @(posedge clk); #1;
    wb_valid_i = 1'b0; wb_rd_i = '0;
  endtask
endmodule